// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is a serial test port for a small device. It follows the usual four-wire scan protocol. A tester drives a test clock, a mode-select line and a serial data line, and has an optional asynchronous reset. The block returns serial data on an output that is enabled only while data is being shifted. A sixteen-state controller steps through the protocol. It selects either a 3-bit instruction path or a data path between the serial input and the serial output.

The data path is either a one-bit bypass stage or a boundary register. The boundary register has three cells for each of `NPINS` pins: one for the value seen at the pad, one for the value to drive out, and one for the drive enable. The register sits between the core logic and the pad buffers. The current instruction decides who controls the pads:
- the core, in normal operation;
- the boundary register's update stage, for external test and clamping;
- nobody, when all outputs are released.

It also decides what the core reads as pin inputs.

The mode-select line and the serial input are sampled on the rising test-clock edge. The serial output, the instruction register and the boundary update stage change on the falling edge.

Top module: `jtag_bscan_port`

## Requirements
- R1: Five consecutive rising clock edges with `tms` high bring the controller to the reset state from any state. After four such edges from Shift-DR, the current instruction is still in force. After the fifth, the instruction reverts to bypass.
- R2: While `trst_n` is low, the controller is held in reset and the instruction is bypass (code 111). The pads then follow the core at once, and the boundary update stage is cleared to zero.
- R3: `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR, and 0 in every other state, including Run-Test-Idle.
- R4: Capture-IR loads 3'b001 into the instruction shift stage. The first three bits shifted out in Shift-IR are therefore 1, 0, 0, and shifting is least significant bit first.
- R5: A newly shifted instruction takes effect only at Update-IR, on the falling clock edge. While the new code sits in the shift stage (Exit1-IR), the previous mode still controls the pads.
- R6: Codes 000 (external test) and 001 (sample/preload) select the boundary register as the data path. Every other code selects the bypass stage, including the unassigned codes 010, 011 and 100.
- R7: With the bypass stage selected, the first bit shifted out of Shift-DR is 0 (captured). Each following output bit equals the input bit of the previous shift.
- R8: Under code 000, each pad output and pad enable come from the update stage, and each core input comes from the update stage's pad-input cell. For pin k, cell 3k is the pad input, 3k+1 the output value and 3k+2 the enable. Cell 0 is nearest `tdo`, and `tdi` enters at cell 3*NPINS-1.
- R9: Under code 001, the pads follow `core_out`/`core_oe` and `core_in` follows `pin_in`. In both boundary modes, Capture-DR loads cell 3k with `pin_in[k]`, cell 3k+1 with `core_out[k]` and cell 3k+2 with `core_oe[k]`. The captured value is shifted out least significant cell first.
- R10: Under code 101, every `pad_oe` bit is 0 whatever the update stage or core holds.
- R11: Under code 110, the pad outputs and enables come from the update stage, and the core still reads `pin_in`.
- R12: The update stage changes only at Update-DR with a boundary code active. Shifting new data leaves the pads unchanged until that state is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in, sampled on rising edge |
| trst_n | input | 1 | Asynchronous active-low port reset |
| tdo | output | 1 | Serial data out, changes on falling edge |
| tdo_oe | output | 1 | Drive enable for `tdo` (0 = high impedance) |
| core_out | input | NPINS | Output values the core wants on the pads |
| core_oe | input | NPINS | Output enables the core wants on the pads |
| pin_in | input | NPINS | Values seen at the pads |
| pad_out | output | NPINS | Output value driven to each pad buffer |
| pad_oe | output | NPINS | Output enable driven to each pad buffer |
| core_in | output | NPINS | Pad input values presented to the core |

## Verification
The bench checks the moments when the pads must not move:
- mid-shift in a boundary mode, where a design that updated on every shift would glitch the pads;
- with a new code still in the instruction shift stage, where an early instruction switch would show;
- after only four `tms`-high edges, where a controller that reset too soon would hand the pads back to the core.

It uses the unassigned codes to expose a decoder that routes them to the boundary chain, which would give a 12-bit rather than 1-bit delay. A random pattern fills the boundary cells, so a wrong cell order or capture source shows up as a specific misplaced bit. Asynchronous reset is applied in external-test mode, so a reset that did not also restore bypass leaves the pads driven from the register.

// File: rtl/jtag_bscan_port.sv
module jtag_bscan_port #(
  parameter int NPINS = 4
) (
  input  logic             tck,
  input  logic             tms,
  input  logic             tdi,
  input  logic             trst_n,
  output logic             tdo,
  output logic             tdo_oe,
  input  logic [NPINS-1:0] core_out,
  input  logic [NPINS-1:0] core_oe,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] core_in
);
  localparam int BLEN = 3 * NPINS;
  localparam logic [2:0] OP_EXT = 3'b000, OP_SMP = 3'b001, OP_HIZ = 3'b101,
                         OP_CLP = 3'b110, OP_BYP = 3'b111;

  typedef enum logic [3:0] {
    S_TLR, S_RTI, S_SDS, S_CDR, S_SDR, S_E1D, S_PDR, S_E2D,
    S_UDR, S_SIS, S_CIR, S_SIR, S_E1I, S_PIR, S_E2I, S_UIR
  } tap_t;

  tap_t state, nxt;
  logic [2:0] ir_sr, ir;
  logic byp;
  logic [BLEN-1:0] bsr_sr, bsr_up;

  always_comb begin
    case (state)
      S_TLR: nxt = tms ? S_TLR : S_RTI;
      S_RTI: nxt = tms ? S_SDS : S_RTI;
      S_SDS: nxt = tms ? S_SIS : S_CDR;
      S_CDR: nxt = tms ? S_E1D : S_SDR;
      S_SDR: nxt = tms ? S_E1D : S_SDR;
      S_E1D: nxt = tms ? S_UDR : S_PDR;
      S_PDR: nxt = tms ? S_E2D : S_PDR;
      S_E2D: nxt = tms ? S_UDR : S_SDR;
      S_UDR: nxt = tms ? S_SDS : S_RTI;
      S_SIS: nxt = tms ? S_TLR : S_CIR;
      S_CIR: nxt = tms ? S_E1I : S_SIR;
      S_SIR: nxt = tms ? S_E1I : S_SIR;
      S_E1I: nxt = tms ? S_UIR : S_PIR;
      S_PIR: nxt = tms ? S_E2I : S_PIR;
      S_E2I: nxt = tms ? S_UIR : S_SIR;
      default: nxt = tms ? S_SDS : S_RTI;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) state <= S_TLR;
    else         state <= nxt;

  wire is_ext = (ir == OP_EXT);
  wire is_smp = (ir == OP_SMP);
  wire is_hiz = (ir == OP_HIZ);
  wire is_clp = (ir == OP_CLP);
  wire bsel   = is_ext | is_smp;
  wire frc    = is_ext | is_clp;

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)              ir_sr <= 3'b001;
    else if (state == S_CIR)  ir_sr <= 3'b001;
    else if (state == S_SIR)  ir_sr <= {tdi, ir_sr[2:1]};

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n)              ir <= OP_BYP;
    else if (state == S_TLR)  ir <= OP_BYP;
    else if (state == S_UIR)  ir <= ir_sr;

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)              byp <= 1'b0;
    else if (state == S_CDR)  byp <= 1'b0;
    else if (state == S_SDR)  byp <= tdi;

  logic [BLEN-1:0] cap;
  for (genvar k = 0; k < NPINS; k++) begin : g_pin
    assign cap[3*k]     = pin_in[k];
    assign cap[3*k+1]   = core_out[k];
    assign cap[3*k+2]   = core_oe[k];
    assign pad_out[k]   = frc ? bsr_up[3*k+1] : core_out[k];
    assign pad_oe[k]    = is_hiz ? 1'b0 : (frc ? bsr_up[3*k+2] : core_oe[k]);
    assign core_in[k]   = is_ext ? bsr_up[3*k] : pin_in[k];
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)                      bsr_sr <= '0;
    else if (bsel && state == S_CDR)  bsr_sr <= cap;
    else if (bsel && state == S_SDR)  bsr_sr <= {tdi, bsr_sr[BLEN-1:1]};

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n)                      bsr_up <= '0;
    else if (bsel && state == S_UDR)  bsr_up <= bsr_sr;

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (state == S_SIR) || (state == S_SDR);
      if (state == S_SIR)      tdo <= ir_sr[0];
      else if (state == S_SDR) tdo <= bsel ? bsr_sr[0] : byp;
    end

  logic [2:0] hi_run;
  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)   hi_run <= 3'd0;
    else if (!tms) hi_run <= 3'd0;
    else if (hi_run != 3'd5) hi_run <= hi_run + 3'd1;

  a_r1_tms_reset: assert property (@(posedge tck) disable iff (!trst_n)
    (hi_run == 3'd5) |-> (state == S_TLR));
  a_r3_tdo_only_shifting: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (state == S_SIR || state == S_SDR));
  a_r4_capture_ir: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_CIR) |=> (ir_sr == 3'b001));
  a_r5_ir_holds: assert property (@(posedge tck) disable iff (!trst_n)
    (state != S_UIR && state != S_TLR) |-> $stable(ir));
  a_r12_update_holds: assert property (@(posedge tck) disable iff (!trst_n)
    (state != S_UDR) |-> $stable(bsr_up));
endmodule

// File: tb/sim_jtag_bscan_port.sv
module sim_jtag_bscan_port;
  localparam int N = 4;
  localparam int L = 3 * N;
  logic tck = 1'b0, tms = 1'b1, tdi = 1'b0, trst_n = 1'b0;
  logic tdo, tdo_oe;
  logic [N-1:0] core_out = '0, core_oe = '0, pin_in = '0;
  logic [N-1:0] pad_out, pad_oe, core_in;
  int runs = 0, fails = 0;
  bit done = 0;
  logic [L-1:0] mupd = '0;
  logic [2:0] mir = 3'b111;

  jtag_bscan_port #(.NPINS(N)) u0 (.tck, .tms, .tdi, .trst_n, .tdo, .tdo_oe,
    .core_out, .core_oe, .pin_in, .pad_out, .pad_oe, .core_in);

  always #10 tck = ~tck;

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [L-1:0] capv(logic [N-1:0] pi, logic [N-1:0] co, logic [N-1:0] ce);
    logic [L-1:0] v;
    for (int k = 0; k < N; k++) begin
      v[3*k] = pi[k]; v[3*k+1] = co[k]; v[3*k+2] = ce[k];
    end
    return v;
  endfunction

  function automatic logic [3*N-1:0] expins(logic [2:0] c, logic [L-1:0] u,
      logic [N-1:0] co, logic [N-1:0] ce, logic [N-1:0] pi);
    logic [N-1:0] o, e, ci;
    for (int k = 0; k < N; k++) begin
      o[k]  = (c == 3'b000 || c == 3'b110) ? u[3*k+1] : co[k];
      e[k]  = (c == 3'b101) ? 1'b0 : ((c == 3'b000 || c == 3'b110) ? u[3*k+2] : ce[k]);
      ci[k] = (c == 3'b000) ? u[3*k] : pi[k];
    end
    return {ci, e, o};
  endfunction

  task automatic chkpins(input string r);
    chk(r, {core_in, pad_oe, pad_out}, expins(mir, mupd, core_out, core_oe, pin_in));
  endtask

  task automatic tclk(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #2;
  endtask

  task automatic ir_shift(input logic [2:0] code, output logic [2:0] cap);
    tclk(1, 0); tclk(1, 0); tclk(0, 0); tclk(0, 0);
    cap[0] = tdo;
    for (int i = 0; i < 3; i++) begin
      tclk(i == 2, code[i]);
      if (i < 2) cap[i+1] = tdo;
    end
  endtask

  task automatic upd_rti();
    tclk(1, 0); tclk(0, 0);
  endtask

  task automatic load(input logic [2:0] code);
    logic [2:0] c;
    ir_shift(code, c);
    upd_rti();
    mir = code;
  endtask

  task automatic dr_shift(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    tclk(1, 0); tclk(0, 0); tclk(0, 0);
    chk("R3 oe in shift", tdo_oe, 1);
    dout[0] = tdo;
    for (int i = 0; i < n; i++) begin
      tclk(i == n - 1, din[i]);
      if (i < n - 1) dout[i+1] = tdo;
    end
  endtask

  task automatic rnd_io();
    core_out = N'($urandom); core_oe = N'($urandom); pin_in = N'($urandom);
  endtask

  function automatic logic [2:0] modecode(int i);
    case (i)
      0: return 3'b111; 1: return 3'b010; 2: return 3'b011;
      3: return 3'b100; 4: return 3'b101; default: return 3'b110;
    endcase
  endfunction

  initial begin
    logic [63:0] o, d;
    logic [2:0] c;
    logic [L-1:0] cv;
    void'($urandom(32'd4242));
    rnd_io();
    repeat (3) @(negedge tck);
    #2;
    chk("R3 reset tdo_oe", tdo_oe, 0);
    chkpins("R2 reset pads follow core");
    trst_n = 1'b1;
    tclk(1, 0); tclk(0, 0);
    chk("R3 oe idle", tdo_oe, 0);

    ir_shift(3'b111, c);
    chk("R4 capture ir", c, 3'b001);
    upd_rti();

    for (int m = 0; m < 6; m++) begin
      load(modecode(m));
      rnd_io(); #1;
      chkpins(m == 4 ? "R10 highz pins" : (m == 5 ? "R11 clamp pins" : "R6 normal pins"));
      if (m == 4) chk("R10 all oe off", pad_oe, 0);
      d = 64'($urandom) & 64'hff;
      dr_shift(8, d, o);
      upd_rti();
      chk("R7 R6 bypass path", o[7:0], {d[6:0], 1'b0});
      chkpins("R12 bypass update no effect");
    end

    load(3'b001);
    for (int it = 0; it < 6; it++) begin
      rnd_io(); #1;
      cv = capv(pin_in, core_out, core_oe);
      chkpins("R9 sample pins follow core");
      d = 64'({$urandom, $urandom}) & {{(64-L){1'b0}}, {L{1'b1}}};
      dr_shift(L, d, o);
      chk("R9 sample capture", o[L-1:0], cv);
      chkpins("R12 hold in exit1");
      upd_rti();
      mupd = d[L-1:0];
      chkpins("R9 sample after preload");
    end

    ir_shift(3'b000, c);
    chkpins("R5 no change before update-ir");
    upd_rti(); mir = 3'b000;
    chkpins("R8 extest drives preload");
    for (int it = 0; it < 6; it++) begin
      rnd_io(); #1;
      cv = capv(pin_in, core_out, core_oe);
      d = 64'({$urandom, $urandom}) & {{(64-L){1'b0}}, {L{1'b1}}};
      dr_shift(L, d, o);
      chk("R9 extest capture", o[L-1:0], cv);
      chkpins("R12 extest hold mid-scan");
      upd_rti();
      mupd = d[L-1:0];
      chkpins("R8 extest pins");
    end

    load(3'b110);
    rnd_io(); #1;
    chkpins("R11 clamp holds register");
    load(3'b101);
    chkpins("R10 highz after clamp");
    chk("R10 oe off", pad_oe, 0);

    load(3'b000);
    rnd_io(); #1;
    dr_shift(L, 64'(mupd), o);
    tclk(1, 0); tclk(1, 0); tclk(1, 0);
    chkpins("R1 four highs keep mode");
    tclk(1, 0);
    mir = 3'b111;
    chkpins("R1 fifth high resets ir");
    chk("R3 oe in reset", tdo_oe, 0);
    tclk(0, 0);

    load(3'b000);
    chkpins("R8 extest again");
    #5 trst_n = 1'b0; #1;
    mir = 3'b111; mupd = '0;
    chkpins("R2 async reset pads");
    @(negedge tck); #2;
    trst_n = 1'b1;
    tclk(0, 0);
    load(3'b110);
    chkpins("R2 update cleared");

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      runs++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule